// File: doc/BRIEF.md
# Syncpoint Counter Bank with Threshold Interrupts

This block keeps a bank of independent 32-bit progress counters that producers advance one step at a time. Each counter carries a small table of one-shot thresholds. A host command port can step a counter, read it back, arm a threshold, or disarm one. Whenever a counter is stepped, every armed threshold it has now reached turns into an interrupt event. Each event carries the counter index and the threshold value, and the threshold is dropped from the table. Events leave through a valid/ready stream towards an interrupt controller that lives outside this block.

A separate, purely combinational wait port compares a selected counter against a target value. A scheduler can use it to stall until work has progressed far enough.

Commands use a single valid/ready handshake. Read, arm and disarm answer with a one-cycle response pulse. Stepping gives no response; its only visible effects are the new count and any events it releases.

Top module: `syncpt_bank`

## Requirements
- R1: A command with `cmdOp` = 0 (step) adds exactly one to counter `cmdId`. A later read returns the stepped value.
- R2: After a step, every armed threshold of that counter that is less than or equal to the new count (unsigned compare) emits exactly one event carrying (`cmdId`, threshold). The threshold is then removed from the table.
- R3: A threshold above the new count stays armed and is tested again on every later step of its counter.
- R4: Arming (`cmdOp` = 2) a value that is already armed on the same counter changes nothing. It uses no slot, it never yields a second event, and its response has `rspFound` = 1. A fresh arm responds with `rspFound` = 0.
- R5: Disarming (`cmdOp` = 3) a value that is armed on that counter removes it and responds with `rspFound` = 1. With no match it responds with `rspFound` = 0, and the table is left unchanged.
- R6: `waitDone` is 1 exactly when the count of counter `waitId` is greater than or equal to `waitTarget`, and it follows the count in the cycle after a step.
- R7: A fresh arm to a counter whose NUM_SLOT slots are all armed responds with `rspOverflow` = 1 and stores nothing. All other responses carry `rspOverflow` = 0.
- R8: Events released by one step leave one per accepted transfer, in ascending slot order. Slots are filled lowest free index first. While any event is pending, `cmdReady` is 0. A stalled event holds its id and threshold steady.
- R9: Synchronous reset (`rst` = 1) sets every counter to zero and empties every threshold slot.
- R10: Thresholds are tested only on steps. Arming a value that the counter has already reached releases nothing until that counter's next step.
- R11: Read (`cmdOp` = 1), arm and disarm produce `rspValid` for one cycle, in the cycle after acceptance. `rspData` holds the counter's value from before the command. A step produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command accepted this cycle when high with cmdValid |
| cmdOp | input | 2 | 0 step, 1 read, 2 arm, 3 disarm |
| cmdId | input | 5 | Counter index |
| cmdValue | input | 32 | Threshold value for arm and disarm |
| rspValid | output | 1 | Response pulse |
| rspData | output | 32 | Counter value before the command |
| rspFound | output | 1 | Matching threshold existed (arm, disarm) |
| rspOverflow | output | 1 | Arm refused, table full |
| waitId | input | 5 | Counter watched by the wait port |
| waitTarget | input | 32 | Target for the wait compare |
| waitDone | output | 1 | Watched count has reached the target |
| evtValid | output | 1 | Interrupt event present |
| evtReady | input | 1 | Consumer takes the event |
| evtId | output | 5 | Counter that released the event |
| evtThresh | output | 32 | Threshold that was reached |

## Verification
The bench fills a table with thresholds that the counter has already passed, mixed with one it has not. It then steps the counter with the event stream throttled. A design that tested only the first match would drop events. One that emitted them out of slot order, or let them change under back-pressure, would mismatch the queued expectations. One that kept accepting commands while events drain would let a queued step slip through. Repeated arms followed by a full table catch a design that lets duplicates consume slots, which would raise overflow too early and fire the same threshold twice. Disarm hits and misses, arms of already-reached values, and a reset taken while thresholds are armed show up as spurious or missing events during later steps.

// File: rtl/syncpt_pkg.sv
package syncpt_pkg;

  typedef enum logic [1:0] {
    OP_INCR   = 2'd0,
    OP_READ   = 2'd1,
    OP_ARM    = 2'd2,
    OP_CANCEL = 2'd3
  } cmd_op_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic doIncr;
    logic doArm;
    logic doCancel;
    logic doPop;
  } ctrl_strobe_t;

endpackage

// File: rtl/syncpt_data.sv
module syncpt_data
  import syncpt_pkg::*;
#(
  parameter int NUM_CNT  = 32,
  parameter int NUM_SLOT = 4,
  parameter int CNT_W    = 32,
  parameter int ID_W     = 5,
  parameter int SLOT_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrl_strobe_t        strobe,
  input  logic [ID_W-1:0]     cmdId,
  input  logic [CNT_W-1:0]    cmdValue,
  input  logic [ID_W-1:0]     popId,
  input  logic [SLOT_W-1:0]   popSlot,
  input  logic [ID_W-1:0]     waitId,
  input  logic [CNT_W-1:0]    waitTarget,
  output logic [NUM_SLOT-1:0] hitMask,
  output logic                dupHit,
  output logic                tableFull,
  output logic [CNT_W-1:0]    cntCur,
  output logic [CNT_W-1:0]    evtThr,
  output logic                waitDone
);

  logic [CNT_W-1:0]    cntMem  [NUM_CNT];
  logic [NUM_SLOT-1:0] slotVld [NUM_CNT];
  logic [CNT_W-1:0]    slotThr [NUM_CNT][NUM_SLOT];

  logic [CNT_W-1:0]    cntNext;
  logic [NUM_SLOT-1:0] eqMask;
  logic [NUM_SLOT-1:0] vldRow;
  logic [SLOT_W-1:0]   freeIdx;
  logic [SLOT_W-1:0]   matchIdx;
  logic                armWrite;

  assign cntCur  = cntMem[cmdId];
  assign cntNext = cntCur + 1'b1;
  assign vldRow  = slotVld[cmdId];

  // per-slot compare against the stepped count and against the command value
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_cmp
    assign hitMask[s] = vldRow[s] && (slotThr[cmdId][s] <= cntNext);
    assign eqMask[s]  = vldRow[s] && (slotThr[cmdId][s] == cmdValue);
  end

  assign dupHit    = |eqMask;
  assign tableFull = &vldRow;

  always_comb begin
    freeIdx  = '0;
    matchIdx = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (!vldRow[i]) freeIdx  = SLOT_W'(i);
      if (eqMask[i])  matchIdx = SLOT_W'(i);
    end
  end

  assign armWrite = strobe.doArm && !dupHit && !tableFull;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CNT; c++) begin
        cntMem[c]  <= '0;
        slotVld[c] <= '0;
      end
    end else begin
      if (strobe.doIncr) cntMem[cmdId] <= cntNext;
      if (armWrite) slotVld[cmdId][freeIdx] <= 1'b1;
      if (strobe.doCancel && dupHit) slotVld[cmdId][matchIdx] <= 1'b0;
      if (strobe.doPop) slotVld[popId][popSlot] <= 1'b0;
    end
  end

  // threshold values need no reset: every slot is qualified by its valid bit
  always_ff @(posedge clk) begin
    if (armWrite) slotThr[cmdId][freeIdx] <= cmdValue;
  end

  assign evtThr   = slotThr[popId][popSlot];
  assign waitDone = cntMem[waitId] >= waitTarget;

endmodule

// File: rtl/syncpt_ctrl.sv
module syncpt_ctrl
  import syncpt_pkg::*;
#(
  parameter int NUM_SLOT = 4,
  parameter int CNT_W    = 32,
  parameter int ID_W     = 5,
  parameter int SLOT_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [1:0]          cmdOp,
  input  logic [ID_W-1:0]     cmdId,
  input  logic [NUM_SLOT-1:0] hitMask,
  input  logic                dupHit,
  input  logic                tableFull,
  input  logic [CNT_W-1:0]    cntCur,
  input  logic [CNT_W-1:0]    evtThr,
  input  logic                evtReady,
  output ctrl_strobe_t        strobe,
  output logic [ID_W-1:0]     popId,
  output logic [SLOT_W-1:0]   popSlot,
  output logic                evtValid,
  output logic [ID_W-1:0]     evtId,
  output logic [CNT_W-1:0]    evtThresh,
  output logic                rspValid,
  output logic [CNT_W-1:0]    rspData,
  output logic                rspFound,
  output logic                rspOverflow
);

  logic [NUM_SLOT-1:0] pendMask;
  logic [ID_W-1:0]     pendId;
  logic                accept;
  cmd_op_e             opDec;

  assign opDec    = cmd_op_e'(cmdOp);
  assign cmdReady = ~|pendMask;
  assign accept   = cmdValid && cmdReady;
  assign evtValid = |pendMask;

  always_comb begin
    popSlot = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (pendMask[i]) popSlot = SLOT_W'(i);
    end
  end

  assign strobe.doIncr   = accept && (opDec == OP_INCR);
  assign strobe.doArm    = accept && (opDec == OP_ARM);
  assign strobe.doCancel = accept && (opDec == OP_CANCEL);
  assign strobe.doPop    = evtValid && evtReady;

  assign popId     = pendId;
  assign evtId     = pendId;
  assign evtThresh = evtThr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendMask <= '0;
      pendId   <= '0;
    end else if (strobe.doIncr) begin
      pendMask <= hitMask;
      pendId   <= cmdId;
    end else if (strobe.doPop) begin
      pendMask <= pendMask & ~(NUM_SLOT'(1) << popSlot);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid    <= 1'b0;
      rspData     <= '0;
      rspFound    <= 1'b0;
      rspOverflow <= 1'b0;
    end else begin
      rspValid <= accept && (opDec != OP_INCR);
      if (accept && (opDec != OP_INCR)) begin
        rspData     <= cntCur;
        rspFound    <= dupHit && (opDec != OP_READ);
        rspOverflow <= strobe.doArm && !dupHit && tableFull;
      end
    end
  end

endmodule

// File: rtl/syncpt_bank.sv
module syncpt_bank
  import syncpt_pkg::*;
#(
  parameter int NUM_CNT  = 32,
  parameter int NUM_SLOT = 4,
  parameter int CNT_W    = 32,
  localparam int ID_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int SLOT_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [1:0]       cmdOp,
  input  logic [ID_W-1:0]  cmdId,
  input  logic [CNT_W-1:0] cmdValue,
  output logic             rspValid,
  output logic [CNT_W-1:0] rspData,
  output logic             rspFound,
  output logic             rspOverflow,
  input  logic [ID_W-1:0]  waitId,
  input  logic [CNT_W-1:0] waitTarget,
  output logic             waitDone,
  output logic             evtValid,
  input  logic             evtReady,
  output logic [ID_W-1:0]  evtId,
  output logic [CNT_W-1:0] evtThresh
);

  ctrl_strobe_t        strobe;
  logic [NUM_SLOT-1:0] hitMask;
  logic                dupHit;
  logic                tableFull;
  logic [CNT_W-1:0]    cntCur;
  logic [CNT_W-1:0]    evtThr;
  logic [ID_W-1:0]     popId;
  logic [SLOT_W-1:0]   popSlot;

  syncpt_ctrl #(
    .NUM_SLOT(NUM_SLOT), .CNT_W(CNT_W), .ID_W(ID_W), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdId(cmdId),
    .hitMask(hitMask), .dupHit(dupHit), .tableFull(tableFull),
    .cntCur(cntCur), .evtThr(evtThr), .evtReady(evtReady),
    .strobe(strobe), .popId(popId), .popSlot(popSlot),
    .evtValid(evtValid), .evtId(evtId), .evtThresh(evtThresh),
    .rspValid(rspValid), .rspData(rspData), .rspFound(rspFound),
    .rspOverflow(rspOverflow)
  );

  syncpt_data #(
    .NUM_CNT(NUM_CNT), .NUM_SLOT(NUM_SLOT), .CNT_W(CNT_W),
    .ID_W(ID_W), .SLOT_W(SLOT_W)
  ) u_data (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cmdId(cmdId), .cmdValue(cmdValue),
    .popId(popId), .popSlot(popSlot),
    .waitId(waitId), .waitTarget(waitTarget),
    .hitMask(hitMask), .dupHit(dupHit), .tableFull(tableFull),
    .cntCur(cntCur), .evtThr(evtThr), .waitDone(waitDone)
  );

endmodule

// File: rtl/syncpt_bank_chk.sv
module syncpt_bank_chk #(
  parameter int ID_W  = 5,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [1:0]       cmdOp,
  input logic             rspValid,
  input logic             rspOverflow,
  input logic             evtValid,
  input logic             evtReady,
  input logic [ID_W-1:0]  evtId,
  input logic [CNT_W-1:0] evtThresh
);

  p_hold_cmds_r8: assert property (@(posedge clk) disable iff (rst)
    evtValid |-> !cmdReady);

  p_evt_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (evtValid && !evtReady) |=> (evtValid && $stable(evtId) && $stable(evtThresh)));

  p_evt_from_step_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(evtValid) |-> $past(cmdValid && cmdReady && cmdOp == 2'd0));

  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $past(cmdValid && cmdReady && cmdOp != 2'd0));

  p_overflow_arm_r7: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspOverflow) |-> $past(cmdOp == 2'd2));

endmodule

bind syncpt_bank syncpt_bank_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
  .rspValid(rspValid), .rspOverflow(rspOverflow),
  .evtValid(evtValid), .evtReady(evtReady), .evtId(evtId), .evtThresh(evtThresh)
);

// File: tb/syncpt_bank_tb.sv
module syncpt_bank_tb;
  localparam int NC = 32;
  localparam int NS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = 2'd0;
  logic [4:0]  cmdId = '0;
  logic [31:0] cmdValue = '0;
  logic        rspValid, rspFound, rspOverflow;
  logic [31:0] rspData;
  logic [4:0]  waitId = '0;
  logic [31:0] waitTarget = '0;
  logic        waitDone;
  logic        evtValid;
  logic        evtReady = 1'b0;
  logic [4:0]  evtId;
  logic [31:0] evtThresh;

  syncpt_bank u_dut (.*);

  // behavioural reference
  int unsigned mCnt [NC];
  bit          mV   [NC][NS];
  int unsigned mT   [NC][NS];
  typedef struct { int id; int unsigned thr; } ev_t;
  ev_t expQ[$];
  bit  expRsp, expFoundChk, expFound, expOvf;
  int unsigned expData;

  int    tests = 0, fails = 0, cyc = 0;
  string curReq = "R9";
  bit    stallOn = 0;
  bit    finished = 0;

  task automatic check(bit ok, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < NC; c++) begin
      mCnt[c] = 0;
      for (int s = 0; s < NS; s++) mV[c][s] = 0;
    end
    expQ.delete();
    expRsp = 0;
  endtask

  // one clock: compare every output against the model, then drive the stream
  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (!rst) begin
      check(cmdReady == (expQ.size() == 0), "cmdReady", cmdReady, expQ.size() == 0);
      check(evtValid == (expQ.size() != 0), "evtValid", evtValid, expQ.size() != 0);
      if (evtValid && expQ.size() != 0) begin
        check(evtId == expQ[0].id, "evtId", evtId, expQ[0].id);
        check(evtThresh == expQ[0].thr, "evtThresh", evtThresh, expQ[0].thr);
      end
      check(waitDone == (mCnt[waitId] >= waitTarget), "waitDone", waitDone,
            mCnt[waitId] >= waitTarget);
      check(rspValid == expRsp, "rspValid", rspValid, expRsp);
      if (expRsp && rspValid) begin
        check(rspData == expData, "rspData", rspData, expData);
        check(rspOverflow == expOvf, "rspOverflow", rspOverflow, expOvf);
        if (expFoundChk) check(rspFound == expFound, "rspFound", rspFound, expFound);
      end
    end
    expRsp   = 0;
    cmdValid = 0;
    evtReady = !stallOn || (cyc % 3 == 0);
    if (!rst && evtReady && evtValid && expQ.size() != 0) void'(expQ.pop_front());
  endtask

  task automatic issue(int op, int id, int unsigned val, output int waited);
    bit done = 0;
    waited = 0;
    while (!done) begin
      cycle();
      if (cmdReady) begin
        cmdValid = 1; cmdOp = 2'(op); cmdId = 5'(id); cmdValue = val;
        expOvf = 0; expFoundChk = 0; expFound = 0;
        if (op == 0) begin
          mCnt[id]++;
          for (int s = 0; s < NS; s++)
            if (mV[id][s] && mT[id][s] <= mCnt[id]) begin
              expQ.push_back('{id, mT[id][s]});
              mV[id][s] = 0;
            end
        end else begin
          expRsp = 1; expData = mCnt[id];
          if (op == 2) begin
            bit dup = 0; int fr = -1;
            for (int s = NS - 1; s >= 0; s--) begin
              if (mV[id][s] && mT[id][s] == val) dup = 1;
              if (!mV[id][s]) fr = s;
            end
            expFoundChk = 1; expFound = dup;
            if (!dup) begin
              if (fr < 0) expOvf = 1;
              else begin mV[id][fr] = 1; mT[id][fr] = val; end
            end
          end else if (op == 3) begin
            expFoundChk = 1;
            for (int s = 0; s < NS; s++)
              if (mV[id][s] && mT[id][s] == val) begin
                mV[id][s] = 0; expFound = 1;
              end
          end
        end
        done = 1;
      end else waited++;
    end
  endtask

  task automatic cmd(int op, int id, int unsigned val);
    int w;
    issue(op, id, val, w);
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic doReset();
    rst = 1;
    modelReset();
    settle(2);
    rst = 0;
  endtask

  initial begin
    int w;
    modelReset();
    doReset();

    // reset state
    curReq = "R9";
    cmd(1, 0, 0); cmd(1, 5, 0); cmd(1, 31, 0);
    waitId = 5; waitTarget = 0; settle(2);
    waitTarget = 1; settle(2);

    // stepping
    curReq = "R1";
    cmd(0, 3, 0); cmd(0, 3, 0); cmd(0, 3, 0); cmd(1, 3, 0);

    // fire and keep
    curReq = "R2";
    cmd(2, 3, 5); cmd(2, 3, 4); cmd(2, 3, 10);
    cmd(0, 3, 0); settle(3);
    cmd(0, 3, 0); settle(3);
    curReq = "R3";
    cmd(0, 3, 0); cmd(0, 3, 0); cmd(1, 3, 0); settle(2);

    // already reached arms, full table, burst under back-pressure
    curReq = "R10";
    for (int i = 0; i < 5; i++) cmd(0, 7, 0);
    cmd(2, 7, 3); cmd(2, 7, 9); cmd(2, 7, 6); cmd(2, 7, 2);
    settle(3);
    curReq = "R7";
    cmd(2, 7, 7); cmd(2, 7, 8);
    curReq = "R8";
    stallOn = 1;
    cmd(0, 7, 0);
    issue(0, 7, 0, w);
    check(w > 0, "step held while events pending", w, 1);
    settle(8);
    stallOn = 0;
    cmd(1, 7, 0);

    // duplicates
    curReq = "R4";
    cmd(2, 9, 4); cmd(2, 9, 4); cmd(2, 9, 5); cmd(2, 9, 6); cmd(2, 9, 7);
    cmd(2, 9, 4);
    for (int i = 0; i < 4; i++) cmd(0, 9, 0);
    settle(3);

    // disarm
    curReq = "R5";
    cmd(3, 9, 6); cmd(3, 9, 6); cmd(3, 9, 100);
    for (int i = 0; i < 3; i++) cmd(0, 9, 0);
    settle(3);

    // wait port
    curReq = "R6";
    waitId = 3; waitTarget = 5; settle(2);
    waitTarget = 6; settle(2);
    cmd(0, 3, 0); settle(2);
    waitTarget = 32'hFFFF_FFFF; settle(2);

    // response pulse
    curReq = "R11";
    cmd(0, 12, 0); settle(1); cmd(1, 12, 0); settle(2);

    // reset with thresholds armed
    curReq = "R9";
    doReset();
    cmd(1, 7, 0); cmd(1, 3, 0);
    for (int i = 0; i < 10; i++) cmd(0, 7, 0);
    settle(3);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule